// File: doc/BRIEF.md
# Raster Scan Timing Generator for RGB Panels

This block drives a raw RGB panel in raster mode. One clock of `clk` is one pixel clock. A horizontal counter walks through each line in the order sync pulse, back porch, active pixels, front porch. A vertical counter walks through the frame in lines, in the same order. Each of the eight widths is a programmable field that holds its width minus one.

During active clocks the block pulls one 16-bit pixel per clock from a ready/valid source. It drives that pixel on the panel data bus together with its 1-based column and row. Outside the active window the bus is held at zero.

Line sync and data launch on the rising edge of the pixel clock. Frame sync and the AC bias line launch on the following falling edge. The AC bias line flips after a programmable number of completed lines. Configuration is captured during reset and again at the last clock of every frame, so software may rewrite it at any time without tearing a frame.

Top module: `lcd_raster_gen`

## Requirements
- R1: Every line is the sync phase (`cfg_hsw`+1 clocks), then the back porch (`cfg_hbp`+1), then the active pixels (`cfg_ppl`+1), then the front porch (`cfg_hfp`+1). Each field holds its width minus one.
- R2: Every frame is the sync phase (`cfg_vsw`+1 lines), then the back porch (`cfg_vbp`+1), then the active lines (`cfg_lpp`+1), then the front porch (`cfg_vfp`+1).
- R3: `lcd_hsync` is at its active level during a line's sync phase, and `lcd_vsync` during the frame's sync lines. Both therefore start at the first clock of a frame. The active level is 1 when the matching invert input (`cfg_hs_inv`, `cfg_vs_inv`) is 0, and 0 when it is 1.
- R4: `lcd_data`, `lcd_hsync`, `pix_valid`, `pix_x` and `pix_y` are registered on the rising edge and show the position the counters held in the clock before. `lcd_vsync` and `lcd_acb` change on the falling edge half a clock later.
- R5: `src_ready` is high exactly in the clocks whose position is active. At the next rising edge `lcd_data` takes `src_data` if `src_valid` is high, and zero if it is low.
- R6: Outside the active window `lcd_data` is zero, `pix_valid` is low and both coordinates are zero.
- R7: In the active window `pix_x` runs from 1 to P = `cfg_ppl`+1, and `pix_y` runs from 1 to L = `cfg_lpp`+1.
- R8: `lcd_acb` inverts each time `cfg_acb` further lines have completed. The line count runs on across frames. A value of 0 freezes the level.
- R9: All configuration inputs, invert bits included, are captured during reset and at the last clock of each frame. A change made mid-frame takes effect only from the next frame.
- R10: While `rst` is high, both syncs sit at their inactive levels and `lcd_data`, `pix_valid`, `src_ready` and `lcd_acb` are 0. The first clock after reset is the first clock of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hsw | input | HW | Line sync width minus one |
| cfg_hbp | input | HW | Line back porch minus one |
| cfg_ppl | input | HW | Pixels per line minus one |
| cfg_hfp | input | HW | Line front porch minus one |
| cfg_vsw | input | VW | Frame sync lines minus one |
| cfg_vbp | input | VW | Frame back porch lines minus one |
| cfg_lpp | input | VW | Lines per panel minus one |
| cfg_vfp | input | VW | Frame front porch lines minus one |
| cfg_acb | input | AW | Lines between AC bias flips, 0 freezes |
| cfg_hs_inv | input | 1 | Line sync active low when 1 |
| cfg_vs_inv | input | 1 | Frame sync active low when 1 |
| src_data | input | DW | Pixel word from source |
| src_valid | input | 1 | Source word valid |
| src_ready | output | 1 | Pixel taken at next rising edge |
| lcd_data | output | DW | Panel data bus |
| lcd_hsync | output | 1 | Line sync, rising-edge launched |
| lcd_vsync | output | 1 | Frame sync, falling-edge launched |
| lcd_acb | output | 1 | AC bias line, falling-edge launched |
| pix_valid | output | 1 | Bus carries an active pixel |
| pix_x | output | HW+1 | Column, 1-based |
| pix_y | output | VW+1 | Row, 1-based |

## Verification
The busiest clock is the last one of a line that is also the last line of a frame. There the configuration reload, the wrap of both counters and an AC bias flip all land together.

The bench forces this coincidence in two ways. One directed case uses minimum widths with a flip count of one, so a flip occurs at every line end. The other rewrites the configuration mid-frame with a different geometry.

A bench model judges every clock. It holds the old settings until the frame boundary and the new ones after it, and keeps counting lines for the AC bias across the switch. The falling-edge outputs are sampled both before and after the falling edge, which pins down the half-clock offset.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  // Phase of one scan axis; the order is the order of traversal
  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_FRONT  = 2'd3
  } scan_phase_e;
endpackage

// File: rtl/lcd_axis_counter.sv
module lcd_axis_counter
  import lcd_raster_pkg::*;
#(
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [FW-1:0] sync_m1,
  input  logic [FW-1:0] back_m1,
  input  logic [FW-1:0] act_m1,
  input  logic [FW-1:0] front_m1,
  output scan_phase_e   phase,
  output logic          at_end,
  output logic [FW-1:0] act_idx
);
  localparam int CW = FW + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] sync_end, act_beg, act_fin, last_pos;

  // phase boundaries derived from the minus-one widths
  always_comb begin
    sync_end = {2'b00, sync_m1} + CW'(1);
    act_beg  = sync_end + {2'b00, back_m1} + CW'(1);
    act_fin  = act_beg + {2'b00, act_m1} + CW'(1);
    last_pos = act_fin + {2'b00, front_m1};
  end

  always_comb begin
    if (cnt < sync_end)      phase = PH_SYNC;
    else if (cnt < act_beg)  phase = PH_BACK;
    else if (cnt < act_fin)  phase = PH_ACTIVE;
    else                     phase = PH_FRONT;
  end

  assign at_end  = (cnt == last_pos);
  assign act_idx = FW'(cnt - act_beg);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= at_end ? '0 : cnt + CW'(1);
  end

  // R1 R2: position never runs past the programmed period
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_pos);

  // R1 R2: wrap returns to the first sync position
  assert_wrap_to_sync_R2: assert property (@(posedge clk) disable iff (rst)
    step && at_end |=> phase == PH_SYNC);

  // R1: phases are visited in order, never skipped
  assert_phase_order_R1: assert property (@(posedge clk) disable iff (rst)
    step && !at_end |=>
      (2'(phase) == 2'($past(phase))) || (2'(phase) == 2'($past(phase)) + 2'd1));
endmodule

// File: rtl/lcd_acb_toggle.sv
module lcd_acb_toggle #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_done,
  input  logic [AW-1:0] lines_n,
  output logic          acb_q
);
  logic [AW-1:0] line_cnt;
  logic [AW:0]   nxt;

  assign nxt = {1'b0, line_cnt} + (AW+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt <= '0;
      acb_q    <= 1'b0;
    end else if (line_done && lines_n != '0) begin
      if (nxt >= {1'b0, lines_n}) begin
        line_cnt <= '0;
        acb_q    <= ~acb_q;
      end else begin
        line_cnt <= nxt[AW-1:0];
      end
    end
  end

  // R8: a zero count freezes the level
  assert_acb_hold_R8: assert property (@(posedge clk) disable iff (rst)
    lines_n == '0 |=> $stable(acb_q));

  // R8: flips happen only at a line boundary
  assert_acb_on_line_R8: assert property (@(posedge clk) disable iff (rst)
    !line_done |=> $stable(acb_q));
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_raster_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] cfg_hsw,
  input  logic [HW-1:0] cfg_hbp,
  input  logic [HW-1:0] cfg_ppl,
  input  logic [HW-1:0] cfg_hfp,
  input  logic [VW-1:0] cfg_vsw,
  input  logic [VW-1:0] cfg_vbp,
  input  logic [VW-1:0] cfg_lpp,
  input  logic [VW-1:0] cfg_vfp,
  input  logic [AW-1:0] cfg_acb,
  input  logic          cfg_hs_inv,
  input  logic          cfg_vs_inv,
  input  logic [DW-1:0] src_data,
  input  logic          src_valid,
  output logic          src_ready,
  output logic [DW-1:0] lcd_data,
  output logic          lcd_hsync,
  output logic          lcd_vsync,
  output logic          lcd_acb,
  output logic          pix_valid,
  output logic [HW:0]   pix_x,
  output logic [VW:0]   pix_y
);
  // shadow copy of the configuration, reloaded at frame boundaries
  logic [HW-1:0] sh_hsw, sh_hbp, sh_ppl, sh_hfp;
  logic [VW-1:0] sh_vsw, sh_vbp, sh_lpp, sh_vfp;
  logic [AW-1:0] sh_acb;
  logic          sh_hs_inv, sh_vs_inv;

  scan_phase_e   h_phase, v_phase;
  logic          h_end, v_end, frame_end, active;
  logic [HW-1:0] h_idx;
  logic [VW-1:0] v_idx;
  logic          acb_q, vs_rise;

  assign frame_end = h_end & v_end;

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      sh_hsw    <= cfg_hsw;
      sh_hbp    <= cfg_hbp;
      sh_ppl    <= cfg_ppl;
      sh_hfp    <= cfg_hfp;
      sh_vsw    <= cfg_vsw;
      sh_vbp    <= cfg_vbp;
      sh_lpp    <= cfg_lpp;
      sh_vfp    <= cfg_vfp;
      sh_acb    <= cfg_acb;
      sh_hs_inv <= cfg_hs_inv;
      sh_vs_inv <= cfg_vs_inv;
    end
  end

  lcd_axis_counter #(.FW(HW)) u_hcnt (
    .clk      (clk),
    .rst      (rst),
    .step     (1'b1),
    .sync_m1  (sh_hsw),
    .back_m1  (sh_hbp),
    .act_m1   (sh_ppl),
    .front_m1 (sh_hfp),
    .phase    (h_phase),
    .at_end   (h_end),
    .act_idx  (h_idx)
  );

  lcd_axis_counter #(.FW(VW)) u_vcnt (
    .clk      (clk),
    .rst      (rst),
    .step     (h_end),
    .sync_m1  (sh_vsw),
    .back_m1  (sh_vbp),
    .act_m1   (sh_lpp),
    .front_m1 (sh_vfp),
    .phase    (v_phase),
    .at_end   (v_end),
    .act_idx  (v_idx)
  );

  lcd_acb_toggle #(.AW(AW)) u_acb (
    .clk       (clk),
    .rst       (rst),
    .line_done (h_end),
    .lines_n   (sh_acb),
    .acb_q     (acb_q)
  );

  assign active    = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
  assign src_ready = active & ~rst;

  // rising-edge launched outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      lcd_hsync <= cfg_hs_inv;
      vs_rise   <= cfg_vs_inv;
      lcd_data  <= '0;
      pix_valid <= 1'b0;
      pix_x     <= '0;
      pix_y     <= '0;
    end else begin
      lcd_hsync <= (h_phase == PH_SYNC) ^ sh_hs_inv;
      vs_rise   <= (v_phase == PH_SYNC) ^ sh_vs_inv;
      lcd_data  <= (active && src_valid) ? src_data : '0;
      pix_valid <= active;
      pix_x     <= active ? ({1'b0, h_idx} + (HW+1)'(1)) : '0;
      pix_y     <= active ? ({1'b0, v_idx} + (VW+1)'(1)) : '0;
    end
  end

  // falling-edge launched outputs
  always_ff @(negedge clk) begin
    if (rst) begin
      lcd_vsync <= cfg_vs_inv;
      lcd_acb   <= 1'b0;
    end else begin
      lcd_vsync <= vs_rise;
      lcd_acb   <= acb_q;
    end
  end

  // R6: data bus is blank whenever no pixel is presented
  assert_blank_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> lcd_data == '0 && pix_x == '0 && pix_y == '0);

  // R5: a granted pixel is presented on the next rising edge
  assert_ready_presents_R5: assert property (@(posedge clk) disable iff (rst)
    src_ready |=> pix_valid);

  // R4: falling-edge copy matches the rising-edge decision
  assert_vsync_follow_R4: assert property (@(posedge clk) disable iff (rst)
    lcd_vsync == vs_rise);

  // R3: both syncs are active on the first clock of a frame
  assert_frame_start_R3: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> ##1 ((lcd_hsync ^ sh_hs_inv) && (vs_rise ^ sh_vs_inv)));

  // R7: coordinates stay inside the programmed panel
  assert_coord_range_R7: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> pix_x >= (HW+1)'(1) && pix_y >= (VW+1)'(1));
endmodule

// File: tb/lcd_raster_gen_bench.sv
module lcd_raster_gen_bench;
  localparam int CLK_PERIOD = 8;
  localparam int HW = 8, VW = 8, AW = 4, DW = 16;

  logic          clk = 1'b0, rst = 1'b1;
  logic [HW-1:0] cfg_hsw, cfg_hbp, cfg_ppl, cfg_hfp;
  logic [VW-1:0] cfg_vsw, cfg_vbp, cfg_lpp, cfg_vfp;
  logic [AW-1:0] cfg_acb;
  logic          cfg_hs_inv, cfg_vs_inv;
  logic [DW-1:0] src_data = '0;
  logic          src_valid = 1'b0;
  logic          src_ready;
  logic [DW-1:0] lcd_data;
  logic          lcd_hsync, lcd_vsync, lcd_acb, pix_valid;
  logic [HW:0]   pix_x;
  logic [VW:0]   pix_y;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    int hsw, hbp, ppl, hfp, vsw, vbp, lpp, vfp, acb;
    bit hinv, vinv;
  } tcfg_t;
  tcfg_t ca, cb;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_raster_gen #(.HW(HW), .VW(VW), .AW(AW), .DW(DW)) u_lcd_raster_gen (
    .clk(clk), .rst(rst),
    .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_ppl(cfg_ppl), .cfg_hfp(cfg_hfp),
    .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_lpp(cfg_lpp), .cfg_vfp(cfg_vfp),
    .cfg_acb(cfg_acb), .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .lcd_data(lcd_data), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .lcd_acb(lcd_acb), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y)
  );

  function automatic int htot(tcfg_t c);
    return c.hsw + c.hbp + c.ppl + c.hfp + 4;
  endfunction
  function automatic int vtot(tcfg_t c);
    return c.vsw + c.vbp + c.lpp + c.vfp + 4;
  endfunction
  function automatic int ftot(tcfg_t c);
    return htot(c) * vtot(c);
  endfunction

  // expected outputs for counter position c (clocks since reset release)
  function automatic void model(input int c0, output bit hs, output bit vs,
                                output bit act, output int x, output int y);
    tcfg_t c;
    int cc, h, l, hb, vb;
    if (c0 < ftot(ca)) begin c = ca; cc = c0; end
    else begin c = cb; cc = c0 - ftot(ca); end
    h  = cc % htot(c);
    l  = (cc / htot(c)) % vtot(c);
    hb = c.hsw + c.hbp + 2;
    vb = c.vsw + c.vbp + 2;
    hs  = (h <= c.hsw) ^ c.hinv;
    vs  = (l <= c.vsw) ^ c.vinv;
    act = (h >= hb) && (h <= hb + c.ppl) && (l >= vb) && (l <= vb + c.lpp);
    x = act ? h - hb + 1 : 0;
    y = act ? l - vb + 1 : 0;
  endfunction

  // AC bias level after k rising edges (lines completed counted across frames)
  function automatic bit acb_level(int k);
    int n;
    if (k <= ftot(ca)) n = k / htot(ca);
    else n = vtot(ca) + (k - ftot(ca)) / htot(cb);
    if (ca.acb == 0) return 1'b0;
    return bit'((n / ca.acb) % 2);
  endfunction

  task automatic check(string req, int actual, int expected);
    vectors++;
    if (actual !== expected) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, actual, expected);
    end
  endtask

  task automatic drive_cfg(tcfg_t c);
    cfg_hsw = HW'(c.hsw); cfg_hbp = HW'(c.hbp); cfg_ppl = HW'(c.ppl); cfg_hfp = HW'(c.hfp);
    cfg_vsw = VW'(c.vsw); cfg_vbp = VW'(c.vbp); cfg_lpp = VW'(c.lpp); cfg_vfp = VW'(c.vfp);
    cfg_acb = AW'(c.acb); cfg_hs_inv = c.hinv; cfg_vs_inv = c.vinv;
  endtask

  function automatic tcfg_t rand_cfg();
    tcfg_t c;
    c.hsw = $urandom % 3; c.hbp = $urandom % 3; c.ppl = $urandom % 12; c.hfp = $urandom % 3;
    c.vsw = $urandom % 2; c.vbp = $urandom % 2; c.lpp = $urandom % 5; c.vfp = $urandom % 2;
    c.acb = $urandom % 4; c.hinv = bit'($urandom % 2); c.vinv = bit'($urandom % 2);
    return c;
  endfunction

  // reset with ca, then run ncyc clocks; cb is applied at clock change_at (0 = never)
  task automatic run(int ncyc, int change_at, string ext);
    bit hs, vs, act, act_now, lv;
    int x, y;
    logic [DW-1:0] ld;
    rst = 1'b1; src_valid = 1'b0; src_data = '0;
    drive_cfg(ca);
    repeat (3) @(posedge clk);
    #1;
    check("R10 hsync in reset", int'(lcd_hsync), int'(ca.hinv));
    check("R10 vsync in reset", int'(lcd_vsync), int'(ca.vinv));
    check("R10 data in reset", int'(lcd_data), 0);
    check("R10 ready in reset", int'(src_ready) + 2*int'(pix_valid) + 4*int'(lcd_acb), 0);
    rst = 1'b0;
    lv = 1'b0; ld = '0;
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (k >= 2) begin
        model(k - 2, hs, vs, act, x, y);
        check({"R4 vsync before falling edge ", ext}, int'(lcd_vsync), int'(vs));
        check({"R4 R8 acb before falling edge ", ext}, int'(lcd_acb), int'(acb_level(k - 1)));
      end
      #(CLK_PERIOD/2);
      if (k == change_at) drive_cfg(cb);
      model(k - 1, hs, vs, act, x, y);
      check({"R1 R3 hsync ", ext}, int'(lcd_hsync), int'(hs));
      check({"R2 R3 R4 vsync ", ext}, int'(lcd_vsync), int'(vs));
      check({"R6 pix_valid ", ext}, int'(pix_valid), int'(act));
      check({"R7 pix_x ", ext}, int'(pix_x), x);
      check({"R7 pix_y ", ext}, int'(pix_y), y);
      check({"R5 R6 lcd_data ", ext}, int'(lcd_data), (act && lv) ? int'(ld) : 0);
      check({"R8 acb ", ext}, int'(lcd_acb), int'(acb_level(k)));
      model(k, hs, vs, act_now, x, y);
      check({"R5 src_ready ", ext}, int'(src_ready), int'(act_now));
      lv = ($urandom % 4) != 0;
      ld = DW'($urandom);
      src_valid = lv;
      src_data  = ld;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    tcfg_t t;
    void'($urandom(32'd4711));
    // directed: minimum widths, bias flips at every line end (frame end coincides)
    t = '{hsw:0, hbp:0, ppl:0, hfp:0, vsw:0, vbp:0, lpp:0, vfp:0, acb:1, hinv:0, vinv:0};
    ca = t; cb = t;
    run(2 * ftot(ca) + 3, 0, "min");
    // directed: frozen bias with both syncs inverted
    t = '{hsw:1, hbp:2, ppl:5, hfp:1, vsw:1, vbp:0, lpp:2, vfp:1, acb:0, hinv:1, vinv:1};
    ca = t; cb = t;
    run(2 * ftot(ca) + 5, 0, "acb0");
    // random geometries
    for (int i = 0; i < 8; i++) begin
      ca = rand_cfg(); cb = ca;
      run(2 * ftot(ca) + htot(ca) + 5, 0, "rand");
    end
    // R9: mid-frame rewrite only applies from the next frame
    for (int i = 0; i < 3; i++) begin
      ca = rand_cfg();
      cb = rand_cfg();
      cb.ppl = ca.ppl + 1 + i; cb.acb = ca.acb;
      run(ftot(ca) + 2 * ftot(cb) + 3, ftot(ca) / 2 + 1, "R9");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule